// File: doc/BRIEF.md
# Blit Parameter Latch and Scaler Loader

This block sits between a small bank of four general coordinate registers, each holding a 12-bit X field and a 12-bit Y field, and the control inputs of a blit engine and its scaler. The host issues a command that names a parameter group. The block takes a snapshot of the coordinate registers that the group uses. When the blit engine is idle, it moves the whole group into its output registers in one clock edge and pulses a load strobe.

The geometry command fills every blit parameter at once. The bitmap line pitch is 16 bits wide and is built by joining the low Y bits of xy0 above its X field. The copy size comes from xy1. The signed source offset comes from xy2 and the signed destination comes from xy3. The scaler command carries a two-bit transfer mask. Bit 0 moves xy0 into the up-scale factors and bit 1 moves xy1 into the down-scale factors. Scaling cannot be switched off. A 1:1 ratio is set by loading neutral factors through this same command.

The control is a two-state machine. ST_IDLE accepts a valid command; that transition is named accept. ST_PEND holds the snapshot. While the engine reports busy, the transition wait keeps it in ST_PEND. When the engine reports idle, the transition commit returns it to ST_IDLE and updates the outputs.

Top module: `blt_param_loader`

## Requirements
- R1: After reset every parameter output is zero and load_stb is low.
- R2: The geometry command (cmd_op = 2'b01) sets bmp_width to {xy0_y[3:0], xy0_x}. A non-zero Y field therefore gives a pitch of 4096 pixels or more, up to 65535.
- R3: The geometry command sets copy_w from xy1_x and copy_h from xy1_y, both as unsigned 12-bit values.
- R4: The geometry command sets src_ox and src_oy from xy2 and sets dst_x and dst_y from xy3, all as two's-complement 12-bit values (-2048 to +2047).
- R5: The scaler command (cmd_op = 2'b10) transfers xy0 X/Y to up_x/up_y when cmd_arg bit 0 is set, and xy1 X/Y to dn_x/dn_y when bit 1 is set. An operand of 0x03 updates both pairs on the same strobe.
- R6: The following commands are ignored, with no output change and no strobe: a scaler command with cmd_arg[1:0] = 0, a scaler command with any of cmd_arg[7:2] set, and cmd_op values 2'b00 and 2'b11.
- R7: Outputs outside the selected group keep their values. Geometry leaves all scale factors unchanged, and a scaler transfer leaves the unselected pair and all geometry unchanged.
- R8: A command is sampled at a rising edge. If blit_busy is low at the next edge, the outputs change at that edge and load_stb is high for exactly one cycle after it.
- R9: While blit_busy is high the load is held back and the outputs do not change. The load uses the coordinate values from the command cycle, even if the coordinate registers change later, and it commits at the first edge where blit_busy is low.
- R10: A command that arrives while a load is pending is dropped and produces no strobe.
- R11: The parameter outputs change only at the edge that raises load_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 01 geometry, 10 scaler, other values ignored |
| cmd_arg | input | 8 | Scaler transfer mask in bits 1:0 |
| xy_x | input | 48 | X fields of xy0..xy3, with xy0 in the low 12 bits |
| xy_y | input | 48 | Y fields of xy0..xy3, with xy0 in the low 12 bits |
| blit_busy | input | 1 | Blit engine is working |
| bmp_width | output | 16 | Source bitmap line pitch |
| copy_w | output | 12 | Copy width |
| copy_h | output | 12 | Copy height |
| src_ox | output | 12 | Signed source X offset |
| src_oy | output | 12 | Signed source Y offset |
| dst_x | output | 12 | Signed destination X |
| dst_y | output | 12 | Signed destination Y |
| up_x | output | 12 | Up-scale factor X |
| up_y | output | 12 | Up-scale factor Y |
| dn_x | output | 12 | Down-scale factor X |
| dn_y | output | 12 | Down-scale factor Y |
| load_stb | output | 1 | One-cycle parameter-valid pulse |

## Verification
The hardest case to reach is a pending load that sits behind a busy engine. The snapshot must outlive changes to the coordinate registers and survive a second command that has to be dropped. The stimulus raises blit_busy before a geometry command and then rewrites all four coordinate registers. It issues a scaler command during the wait and checks for several cycles that nothing changes. Only then does it drop blit_busy. The scoreboard entry for that strobe holds the values from the first command cycle, so a commit of live values or of the dropped command shows up as a mismatch.

// File: rtl/bpl_pkg.sv
package bpl_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_GEOM  = 2'b01,
        OP_SCALE = 2'b10,
        OP_RSVD  = 2'b11
    } bpl_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } bpl_state_e;

    localparam int NUM_XY = 4;
    localparam int NUM_SC = 2;
endpackage

// File: rtl/bpl_fsm.sv
module bpl_fsm
    import bpl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_arg,
    input  logic       blit_busy,
    output logic       accept,
    output logic       commit
);
    bpl_state_e state, state_nx;
    logic       cmd_ok;

    always_comb begin
        unique case (bpl_op_e'(cmd_op))
            OP_GEOM:  cmd_ok = 1'b1;
            OP_SCALE: cmd_ok = (cmd_arg[7:2] == 6'd0) && (cmd_arg[1:0] != 2'd0);
            default:  cmd_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && cmd_ok) begin
                    accept   = 1'b1;
                    state_nx = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!blit_busy) begin
                    commit   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R9: a pending load stays pending while the engine is busy
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && blit_busy) |=> (state == ST_PEND));
endmodule

// File: rtl/bpl_stage.sv
module bpl_stage
    import bpl_pkg::*;
#(
    parameter int CW = 12,
    localparam int XYW = NUM_XY * CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic [1:0]     cmd_op,
    input  logic [1:0]     cmd_mask,
    input  logic [XYW-1:0] xy_x,
    input  logic [XYW-1:0] xy_y,
    output logic [1:0]     st_op,
    output logic [1:0]     st_mask,
    output logic [XYW-1:0] st_x,
    output logic [XYW-1:0] st_y
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_op   <= OP_NONE;
            st_mask <= '0;
            st_x    <= '0;
            st_y    <= '0;
        end else if (accept) begin
            st_op   <= cmd_op;
            st_mask <= cmd_mask;
            st_x    <= xy_x;
            st_y    <= xy_y;
        end
    end
endmodule

// File: rtl/bpl_regs.sv
module bpl_regs
    import bpl_pkg::*;
#(
    parameter int CW = 12,
    parameter int WW = 16,
    localparam int XYW = NUM_XY * CW,
    localparam int XW  = WW - CW,
    localparam int SCW = NUM_SC * CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [1:0]           st_op,
    input  logic [1:0]           st_mask,
    input  logic [XYW-1:0]       st_x,
    input  logic [XYW-1:0]       st_y,
    output logic [WW-1:0]        bmp_width,
    output logic [CW-1:0]        copy_w,
    output logic [CW-1:0]        copy_h,
    output logic signed [CW-1:0] src_ox,
    output logic signed [CW-1:0] src_oy,
    output logic signed [CW-1:0] dst_x,
    output logic signed [CW-1:0] dst_y,
    output logic [SCW-1:0]       sc_x,
    output logic [SCW-1:0]       sc_y,
    output logic                 load_stb
);
    logic geom_go;
    assign geom_go = commit && (st_op == OP_GEOM);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bmp_width <= '0;
            copy_w    <= '0;
            copy_h    <= '0;
            src_ox    <= '0;
            src_oy    <= '0;
            dst_x     <= '0;
            dst_y     <= '0;
        end else if (geom_go) begin
            bmp_width <= {st_y[XW-1:0], st_x[CW-1:0]};
            copy_w    <= st_x[CW +: CW];
            copy_h    <= st_y[CW +: CW];
            src_ox    <= st_x[2*CW +: CW];
            src_oy    <= st_y[2*CW +: CW];
            dst_x     <= st_x[3*CW +: CW];
            dst_y     <= st_y[3*CW +: CW];
        end
    end

    for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sc_x[g*CW +: CW] <= '0;
                sc_y[g*CW +: CW] <= '0;
            end else if (commit && st_op == OP_SCALE && st_mask[g]) begin
                sc_x[g*CW +: CW] <= st_x[g*CW +: CW];
                sc_y[g*CW +: CW] <= st_y[g*CW +: CW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) load_stb <= 1'b0;
        else        load_stb <= commit;
    end

    // R8: the strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R11: parameters move only together with the strobe
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |-> ($stable(bmp_width) && $stable(copy_w) && $stable(copy_h) &&
                       $stable(src_ox) && $stable(src_oy) && $stable(dst_x) &&
                       $stable(dst_y) && $stable(sc_x) && $stable(sc_y)));
endmodule

// File: rtl/blt_param_loader.sv
module blt_param_loader
    import bpl_pkg::*;
#(
    parameter int CW = 12,
    parameter int WW = 16,
    localparam int XYW = NUM_XY * CW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [7:0]           cmd_arg,
    input  logic [XYW-1:0]       xy_x,
    input  logic [XYW-1:0]       xy_y,
    input  logic                 blit_busy,
    output logic [WW-1:0]        bmp_width,
    output logic [CW-1:0]        copy_w,
    output logic [CW-1:0]        copy_h,
    output logic signed [CW-1:0] src_ox,
    output logic signed [CW-1:0] src_oy,
    output logic signed [CW-1:0] dst_x,
    output logic signed [CW-1:0] dst_y,
    output logic [CW-1:0]        up_x,
    output logic [CW-1:0]        up_y,
    output logic [CW-1:0]        dn_x,
    output logic [CW-1:0]        dn_y,
    output logic                 load_stb
);
    logic                    accept, commit;
    logic [1:0]              st_op, st_mask;
    logic [XYW-1:0]          st_x, st_y;
    logic [NUM_SC*CW-1:0]    sc_x, sc_y;

    bpl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .blit_busy(blit_busy), .accept(accept), .commit(commit)
    );

    bpl_stage #(.CW(CW)) u_stage (
        .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_op(cmd_op),
        .cmd_mask(cmd_arg[1:0]), .xy_x(xy_x), .xy_y(xy_y),
        .st_op(st_op), .st_mask(st_mask), .st_x(st_x), .st_y(st_y)
    );

    bpl_regs #(.CW(CW), .WW(WW)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .st_op(st_op), .st_mask(st_mask),
        .st_x(st_x), .st_y(st_y), .bmp_width(bmp_width), .copy_w(copy_w),
        .copy_h(copy_h), .src_ox(src_ox), .src_oy(src_oy), .dst_x(dst_x),
        .dst_y(dst_y), .sc_x(sc_x), .sc_y(sc_y), .load_stb(load_stb)
    );

    assign up_x = sc_x[0 +: CW];
    assign up_y = sc_y[0 +: CW];
    assign dn_x = sc_x[CW +: CW];
    assign dn_y = sc_y[CW +: CW];

    // R8/R9: a strobe always follows an edge at which the engine was idle
    a_r9_stb_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> !$past(blit_busy));
endmodule

// File: tb/test_blt_param_loader.sv
module test_blt_param_loader;
    localparam int CW = 12;
    localparam int VW = 136;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = 2'b00;
    logic [7:0]      cmd_arg = 8'h00;
    logic [4*CW-1:0] xy_x = '0;
    logic [4*CW-1:0] xy_y = '0;
    logic            blit_busy = 1'b0;
    logic [15:0]     bmp_width;
    logic [CW-1:0]   copy_w, copy_h, up_x, up_y, dn_x, dn_y;
    logic signed [CW-1:0] src_ox, src_oy, dst_x, dst_y;
    logic            load_stb;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic [VW-1:0] sb_q[$];
    logic [VW-1:0] model;
    logic prev_stb = 1'b0;

    always #5 clk = ~clk;

    blt_param_loader i_blt_param_loader (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .xy_x(xy_x), .xy_y(xy_y), .blit_busy(blit_busy),
        .bmp_width(bmp_width), .copy_w(copy_w), .copy_h(copy_h), .src_ox(src_ox),
        .src_oy(src_oy), .dst_x(dst_x), .dst_y(dst_y), .up_x(up_x), .up_y(up_y),
        .dn_x(dn_x), .dn_y(dn_y), .load_stb(load_stb)
    );

    function automatic logic [VW-1:0] outs();
        return {bmp_width, copy_w, copy_h, src_ox, src_oy, dst_x, dst_y,
                up_x, up_y, dn_x, dn_y};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_xy(input int i, input logic [CW-1:0] x, input logic [CW-1:0] y);
        xy_x[i*CW +: CW] = x;
        xy_y[i*CW +: CW] = y;
    endtask

    function automatic logic [CW-1:0] gx(input int i);
        return xy_x[i*CW +: CW];
    endfunction
    function automatic logic [CW-1:0] gy(input int i);
        return xy_y[i*CW +: CW];
    endfunction

    // driver: push the expected result the requirements predict
    task automatic issue(input logic [1:0] op, input logic [7:0] arg, input bit expect_load);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg;
        if (expect_load) begin
            if (op == 2'b01) begin
                model[135:120] = {gy(0)[3:0], gx(0)};
                model[119:108] = gx(1);
                model[107:96]  = gy(1);
                model[95:84]   = gx(2);
                model[83:72]   = gy(2);
                model[71:60]   = gx(3);
                model[59:48]   = gy(3);
            end else begin
                if (arg[0]) begin model[47:36] = gx(0); model[35:24] = gy(0); end
                if (arg[1]) begin model[23:12] = gx(1); model[11:0]  = gy(1); end
            end
            sb_q.push_back(model);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // monitor: compare every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (load_stb) begin
                strobes++;
                chk(!prev_stb, "R8 strobe width", {135'd0, prev_stb}, '0);
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected strobe", outs(), '0);
                end else begin
                    logic [VW-1:0] e;
                    e = sb_q.pop_front();
                    chk(outs() == e, "R2 R3 R4 R5 R7 strobe contents", outs(), e);
                end
            end
            prev_stb = load_stb;
        end
    end

    task automatic quiet(input int n, input string req);
        logic [VW-1:0] snap;
        snap = outs();
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(!load_stb && outs() == snap, req, outs(), snap);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(outs() == '0 && !load_stb, "R1 reset", outs(), '0);
        rst_n = 1'b1;

        // R2 R3 R4 geometry with Y=0 in xy0
        set_xy(0, 12'h123, 12'h000);
        set_xy(1, 12'h0FF, 12'h080);
        set_xy(2, 12'hF00, 12'h7FF);
        set_xy(3, 12'h800, 12'h001);
        issue(2'b01, 8'h00, 1'b1);
        @(negedge clk);
        chk(load_stb == 1'b1, "R8 strobe timing", {135'd0, load_stb}, 1);
        chk(bmp_width == 16'h0123, "R2 narrow pitch", bmp_width, 16'h0123);
        chk(src_ox == -12'sd256 && dst_x == -12'sd2048, "R4 signed", {src_ox, dst_x}, {12'hF00, 12'h800});

        // R2 wide pitch from non-zero Y
        set_xy(0, 12'hABC, 12'h005);
        set_xy(1, 12'hFFF, 12'hFFF);
        issue(2'b01, 8'h00, 1'b1);
        @(negedge clk);
        chk(bmp_width == 16'h5ABC, "R2 wide pitch", bmp_width, 16'h5ABC);
        chk(copy_w == 12'hFFF && copy_h == 12'hFFF, "R3 max copy", {copy_w, copy_h}, 24'hFFFFFF);

        // R5 R7 up-scale only
        set_xy(0, 12'h400, 12'h800);
        set_xy(1, 12'h111, 12'h222);
        issue(2'b10, 8'h01, 1'b1);
        @(negedge clk);
        chk(up_x == 12'h400 && dn_x == 12'h000 && bmp_width == 16'h5ABC,
            "R7 unselected kept", {up_x, dn_x}, {12'h400, 12'h000});

        // R5 both pairs in one strobe
        set_xy(0, 12'h0AA, 12'h0BB);
        set_xy(1, 12'h0CC, 12'h0DD);
        issue(2'b10, 8'h03, 1'b1);
        @(negedge clk);
        chk(up_y == 12'h0BB && dn_y == 12'h0DD, "R5 both", {up_y, dn_y}, {12'h0BB, 12'h0DD});

        // R6 ignored commands
        set_xy(0, 12'h777, 12'h777);
        set_xy(1, 12'h666, 12'h666);
        issue(2'b10, 8'h00, 1'b0);
        quiet(3, "R6 scale mask zero");
        issue(2'b10, 8'h07, 1'b0);
        quiet(3, "R6 upper operand bits");
        issue(2'b11, 8'h03, 1'b0);
        quiet(3, "R6 reserved op");
        issue(2'b00, 8'h03, 1'b0);
        quiet(3, "R6 null op");

        // R7 geometry leaves scalers
        set_xy(2, 12'h001, 12'h002);
        issue(2'b01, 8'h00, 1'b1);
        @(negedge clk);
        chk(up_x == 12'h0AA && dn_x == 12'h0CC, "R7 geometry keeps scale", {up_x, dn_x}, {12'h0AA, 12'h0CC});

        // R9 R10 held load with snapshot and dropped second command
        blit_busy = 1'b1;
        set_xy(0, 12'h321, 12'h00F);
        set_xy(1, 12'h010, 12'h020);
        set_xy(2, 12'h7FF, 12'h800);
        set_xy(3, 12'h030, 12'h040);
        issue(2'b01, 8'h00, 1'b1);
        set_xy(0, 12'hEEE, 12'hEEE);
        set_xy(1, 12'hDDD, 12'hDDD);
        set_xy(2, 12'hCCC, 12'hCCC);
        set_xy(3, 12'hBBB, 12'hBBB);
        quiet(5, "R9 held while busy");
        issue(2'b10, 8'h03, 1'b0);
        quiet(2, "R10 pending drop");
        blit_busy = 1'b0;
        @(negedge clk);
        chk(load_stb == 1'b1, "R9 commit after idle", {135'd0, load_stb}, 1);
        chk(bmp_width == 16'hF321, "R9 snapshot", bmp_width, 16'hF321);
        quiet(4, "R10 no second strobe");
        chk(up_x == 12'h0AA, "R10 scale untouched", up_x, 12'h0AA);

        // back-to-back loads
        for (int n = 0; n < 3; n++) begin
            set_xy(0, 12'(n * 5 + 1), 12'(n));
            issue(2'b01, 8'h00, 1'b1);
        end
        repeat (3) @(negedge clk);

        chk(sb_q.size() == 0, "R8 all loads seen", 136'(sb_q.size()), 0);
        chk(strobes == 9, "R11 strobe count", 136'(strobes), 9);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule